// File: doc/BRIEF.md
# SCL Clock Timing Generator

This block produces the serial clock waveform for a two-wire bus master. A programmable prescaler divides the functional clock into a slower internal tick. A phase sequencer then counts the low and high halves of each SCL period in those ticks. Each half lasts its programmed value plus a fixed offset (`OFFSET` ticks, six by default).

Each timing word holds two settings. The lower byte sets the standard or fast-mode duration. The upper byte sets the high-speed duration. A transfer always starts on the lower-byte timing, which keeps the master-code phase of a high-speed transfer within fast-mode limits. Once the bus engine reports that the master code is done, and high-speed mode is selected, every later phase takes its length from the upper byte.

The bus engine starts a clock train with `start_req` and ends it with `stop_req`. The block reports a change strobe at the start of each low phase and a sample strobe at the middle of each high phase. A device that holds SCL low during a high phase stretches that phase, and the count resumes once the line reads high again. Clearing `enable` releases SCL and holds all counters in reset.

Top module: `scl_timing_gen`

## Requirements
- R1: While in reset or while `enable` is low, `scl_out` is 1, both strobes are 0 and `hs_active` is 0. A `start_req` seen while disabled is ignored.
- R2: The tick counter divides `clk` by prescaler value p plus one. Every phase therefore lasts a whole multiple of p+1 clock cycles.
- R3: After `start_req` in the idle state, the first low phase lasts (L[7:0]+OFFSET)*(p+1) cycles, where L is the low timing word.
- R4: A high phase using fast timing lasts (H[7:0]+OFFSET)*(p+1) cycles, where H is the high timing word.
- R5: If `mcode_done` pulses while `hs_mode` is 1 and a transfer is running, `hs_active` rises. Every phase that starts afterwards uses bits 15:8 of its word. If `hs_mode` is 0, the lower byte stays in use.
- R6: During a high phase, cycles in which `scl_in` reads 0 are not counted, so the phase is lengthened by the stretch.
- R7: `change_stb` pulses for exactly the first cycle of each low phase. `sample_stb` pulses exactly once in each unstretched high phase, while `scl_out` is 1. The two strobes never coincide.
- R8: A `stop_req` during a transfer lets the current high phase finish. SCL then stays high and `hs_active` clears.
- R9: Configuration writes take effect only while `enable` is 0. Select 0 writes the prescaler, select 1 the low word and select 2 the high word. A write while enabled leaves the timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Module enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 prescaler, 1 low word, 2 high word |
| cfg_wdata | input | 16 | Configuration write data |
| hs_mode | input | 1 | High-speed operation selected |
| start_req | input | 1 | Begin clock generation |
| stop_req | input | 1 | End clock generation after the current high phase |
| mcode_done | input | 1 | Master-code phase finished |
| scl_in | input | 1 | Sensed SCL line level |
| scl_out | output | 1 | SCL drive, 0 = pull low, 1 = release |
| change_stb | output | 1 | First cycle of a low phase |
| sample_stb | output | 1 | Mid-point of a high phase |
| hs_active | output | 1 | High-speed timing in use |

## Verification
Some properties are checked on every cycle by the assertions:
- SCL is released while the block is disabled.
- Each strobe appears only at its own line level, and the two strobes never coincide.
- Every falling edge of SCL carries a change strobe.
- A sensed low level holds a driven-high SCL high.
- `hs_active` drops on disable.

Other behaviour shows up only in the bench scenarios:
- The exact phase lengths for several prescaler and timing pairs.
- The switch to the upper byte after the master code.
- The extra length added by a stretch.
- The clean stop.
- Writes that are ignored while the block is enabled.

// File: rtl/scl_tmg_pkg.sv
package scl_tmg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  localparam logic [1:0] SEL_PSC  = 2'd0;
  localparam logic [1:0] SEL_LOW  = 2'd1;
  localparam logic [1:0] SEL_HIGH = 2'd2;
endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs #(
  parameter int PSC_W  = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [PSC_W-1:0]  psc_q,
  output logic [WORD_W-1:0] low_q,
  output logic [WORD_W-1:0] high_q
);
  import scl_tmg_pkg::*;

  logic wr_ok;
  assign wr_ok = cfg_we && !enable;

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_q  <= '0;
      low_q  <= '0;
      high_q <= '0;
    end else if (wr_ok) begin
      case (cfg_sel)
        SEL_PSC:  psc_q  <= cfg_wdata[PSC_W-1:0];
        SEL_LOW:  low_q  <= cfg_wdata;
        SEL_HIGH: high_q <= cfg_wdata;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PSC_W-1:0] div,
  output logic             tick
);
  logic [PSC_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == div) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm #(
  parameter int WORD_W = 16,
  parameter int OFFSET = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              start_req,
  input  logic              stop_req,
  input  logic              mcode_done,
  input  logic              hs_mode,
  input  logic              tick,
  input  logic              scl_in,
  input  logic [WORD_W-1:0] low_word,
  input  logic [WORD_W-1:0] high_word,
  output logic              running,
  output logic              scl_out,
  output logic              change_stb,
  output logic              sample_stb,
  output logic              hs_active
);
  import scl_tmg_pkg::*;

  localparam int HALF_W = WORD_W / 2;
  localparam int LEN_W  = $clog2((1 << HALF_W) + OFFSET);

  phase_e           state_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  logic             stop_pend_q;
  logic             hs_q;
  logic             last_tick;
  logic             high_tick;

  function automatic logic [LEN_W-1:0] phase_len(input logic [WORD_W-1:0] w,
                                                 input logic hs);
    logic [HALF_W-1:0] v;
    v = hs ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0];
    return LEN_W'(v) + LEN_W'(OFFSET);
  endfunction

  assign last_tick = (cnt_q == len_q - LEN_W'(1));
  assign high_tick = tick && scl_in;
  assign running   = (state_q != PH_IDLE);
  assign scl_out   = (state_q != PH_LOW);
  assign hs_active = hs_q;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state_q     <= PH_IDLE;
      cnt_q       <= '0;
      len_q       <= '0;
      stop_pend_q <= 1'b0;
      hs_q        <= 1'b0;
      change_stb  <= 1'b0;
      sample_stb  <= 1'b0;
    end else begin
      change_stb <= 1'b0;
      sample_stb <= 1'b0;
      if (stop_req && running) stop_pend_q <= 1'b1;
      if (mcode_done && hs_mode && running) hs_q <= 1'b1;
      case (state_q)
        PH_IDLE: begin
          if (start_req) begin
            state_q     <= PH_LOW;
            cnt_q       <= '0;
            len_q       <= phase_len(low_word, 1'b0);
            change_stb  <= 1'b1;
            stop_pend_q <= 1'b0;
          end
        end
        PH_LOW: begin
          if (tick) begin
            if (last_tick) begin
              state_q <= PH_HIGH;
              cnt_q   <= '0;
              len_q   <= phase_len(high_word, hs_q);
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        PH_HIGH: begin
          if (high_tick) begin
            if (cnt_q == (len_q >> 1)) sample_stb <= 1'b1;
            if (last_tick) begin
              cnt_q <= '0;
              if (stop_pend_q || stop_req) begin
                state_q     <= PH_IDLE;
                stop_pend_q <= 1'b0;
                hs_q        <= 1'b0;
              end else begin
                state_q    <= PH_LOW;
                len_q      <= phase_len(low_word, hs_q);
                change_stb <= 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int PSC_W  = 8,
  parameter int WORD_W = 16,
  parameter int OFFSET = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              hs_mode,
  input  logic              start_req,
  input  logic              stop_req,
  input  logic              mcode_done,
  input  logic              scl_in,
  output logic              scl_out,
  output logic              change_stb,
  output logic              sample_stb,
  output logic              hs_active
);
  logic [PSC_W-1:0]  psc;
  logic [WORD_W-1:0] low_word;
  logic [WORD_W-1:0] high_word;
  logic              running;
  logic              tick;

  scl_cfg_regs #(.PSC_W(PSC_W), .WORD_W(WORD_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .psc_q     (psc),
    .low_q     (low_word),
    .high_q    (high_word)
  );

  scl_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk  (clk),
    .rst  (rst),
    .run  (enable && running),
    .div  (psc),
    .tick (tick)
  );

  scl_phase_fsm #(.WORD_W(WORD_W), .OFFSET(OFFSET)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .start_req  (start_req),
    .stop_req   (stop_req),
    .mcode_done (mcode_done),
    .hs_mode    (hs_mode),
    .tick       (tick),
    .scl_in     (scl_in),
    .low_word   (low_word),
    .high_word  (high_word),
    .running    (running),
    .scl_out    (scl_out),
    .change_stb (change_stb),
    .sample_stb (sample_stb),
    .hs_active  (hs_active)
  );
endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic start_req,
  input logic scl_in,
  input logic scl_out,
  input logic change_stb,
  input logic sample_stb,
  input logic hs_active
);
  AST_DIS_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !enable |=> scl_out); // R1
  AST_DIS_HS_CLR: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !hs_active); // R5
  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (enable && scl_out && !scl_in && !start_req) |=> scl_out); // R6
  AST_CHG_AT_LOW: assert property (@(posedge clk) disable iff (rst)
    change_stb |-> !scl_out); // R7
  AST_SMP_AT_HIGH: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> scl_out); // R7
  AST_FALL_HAS_CHG: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_out) |-> change_stb); // R7
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(sample_stb && change_stb)); // R7
endmodule

bind scl_timing_gen scl_timing_gen_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .enable     (enable),
  .start_req  (start_req),
  .scl_in     (scl_in),
  .scl_out    (scl_out),
  .change_stb (change_stb),
  .sample_stb (sample_stb),
  .hs_active  (hs_active)
);

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;
  localparam int OFF = 6;
  localparam int CAP = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = '0;
  logic hs_mode = 1'b0;
  logic start_req = 1'b0;
  logic stop_req = 1'b0;
  logic mcode_done = 1'b0;
  logic stretch = 1'b0;
  logic scl_in;
  logic scl_out, change_stb, sample_stb, hs_active;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;
  assign scl_in = scl_out && !stretch;

  scl_timing_gen u_dut (
    .clk(clk), .rst(rst), .enable(enable), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .hs_mode(hs_mode), .start_req(start_req),
    .stop_req(stop_req), .mcode_done(mcode_done), .scl_in(scl_in),
    .scl_out(scl_out), .change_stb(change_stb), .sample_stb(sample_stb),
    .hs_active(hs_active)
  );

  // {prescaler, low byte, high byte}
  localparam logic [23:0] VEC [4] = '{
    {8'd0, 8'd2,  8'd3},
    {8'd1, 8'd4,  8'd1},
    {8'd3, 8'd0,  8'd0},
    {8'd2, 8'd10, 8'd5}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Starts a transfer, measures low1/high1/low2, stops, checks idle stays high.
  task automatic run_xfer(input bit mc, output int lo1, output int hi1,
                          output int lo2, output int smp, output bit chg,
                          output bit idle_ok);
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    chg = change_stb;
    lo1 = 0;
    while (!scl_out && lo1 < CAP) begin
      mcode_done = mc && (lo1 == 0);
      lo1++; @(negedge clk);
    end
    mcode_done = 1'b0;
    hi1 = 0; smp = 0;
    while (scl_out && hi1 < CAP) begin
      if (sample_stb) smp++;
      hi1++; @(negedge clk);
    end
    lo2 = 0; stop_req = 1'b1;
    while (!scl_out && lo2 < CAP) begin
      lo2++; @(negedge clk); stop_req = 1'b0;
    end
    stop_req = 1'b0;
    idle_ok = 1'b1;
    for (int k = 0; k < 3 * hi1 + 20; k++) begin
      if (!scl_out) idle_ok = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    #400000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int lo1, hi1, lo2, smp, cnt;
    bit chg, idle_ok;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(scl_out && !change_stb && !sample_stb && !hs_active, "R1 reset", scl_out, 1);

    foreach (VEC[i]) begin
      int p, l, h;
      p = VEC[i][23:16]; l = VEC[i][15:8]; h = VEC[i][7:0];
      enable = 1'b0;
      wr(2'd0, 16'(p));
      wr(2'd1, {8'hAA, 8'(l)});
      wr(2'd2, {8'h55, 8'(h)});
      @(negedge clk); enable = 1'b1;
      run_xfer(1'b0, lo1, hi1, lo2, smp, chg, idle_ok);
      chk(lo1 == (l + OFF) * (p + 1), "R3 R2 low phase", lo1, (l + OFF) * (p + 1));
      chk(hi1 == (h + OFF) * (p + 1), "R4 R2 high phase", hi1, (h + OFF) * (p + 1));
      chk(lo2 == (l + OFF) * (p + 1), "R3 second low", lo2, (l + OFF) * (p + 1));
      chk(smp == 1, "R7 sample strobes", smp, 1);
      chk(chg, "R7 change strobe", chg, 1);
      chk(idle_ok, "R8 idle after stop", idle_ok, 1);
    end

    // R9: writes while enabled are ignored (last vector p=2,l=10,h=5 stays)
    wr(2'd1, 16'h0001);
    wr(2'd0, 16'h0000);
    run_xfer(1'b0, lo1, hi1, lo2, smp, chg, idle_ok);
    chk(lo1 == 16 * 3, "R9 ignored write", lo1, 48);

    // R5: high-speed timing after master code
    enable = 1'b0;
    wr(2'd0, 16'd0);
    wr(2'd1, 16'h0502);
    wr(2'd2, 16'h0301);
    hs_mode = 1'b1;
    @(negedge clk); enable = 1'b1;
    run_xfer(1'b1, lo1, hi1, lo2, smp, chg, idle_ok);
    chk(lo1 == 8, "R5 fast low before switch", lo1, 8);
    chk(hi1 == 9, "R5 hs high", hi1, 9);
    chk(lo2 == 11, "R5 hs low", lo2, 11);
    chk(!hs_active, "R8 hs cleared at stop", hs_active, 0);
    // R5 without hs_mode: lower byte kept
    hs_mode = 1'b0;
    run_xfer(1'b1, lo1, hi1, lo2, smp, chg, idle_ok);
    chk(hi1 == 7, "R5 no hs_mode", hi1, 7);

    // R6 stretch: high len 7, hold line low 20 cycles
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    while (!scl_out) @(negedge clk);
    cnt = 0; smp = 0;
    while (scl_out && cnt < CAP) begin
      stretch = (cnt < 20);
      if (sample_stb) smp++;
      cnt++; @(negedge clk);
    end
    stretch = 1'b0;
    chk(cnt == 27, "R6 stretched high", cnt, 27);
    chk(smp == 1, "R7 one sample in stretched phase", smp, 1);
    stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    repeat (40) @(negedge clk);

    // R1 disable mid-transfer releases SCL
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    repeat (2) @(negedge clk);
    chk(!scl_out, "R1 low before disable", scl_out, 0);
    enable = 1'b0;
    @(negedge clk);
    chk(scl_out, "R1 released on disable", scl_out, 1);
    start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    enable = 1'b1;
    idle_ok = 1'b1;
    for (int k = 0; k < 30; k++) begin
      if (!scl_out || change_stb) idle_ok = 1'b0;
      @(negedge clk);
    end
    chk(idle_ok, "R1 start ignored while disabled", idle_ok, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule